// File: doc/BRIEF.md
# Self-Restoring S-Box Memory Bank

This block stores the four key-dependent substitution tables used by two parallel password-hashing engines. Four on-chip memories, each four table-lengths deep, hold the tables. The lower half of every memory is a working area that the engines read and overwrite while they compute a hash. The upper half holds a pristine copy of the starting table values, one copy for each engine. A write can never reach the upper half, because a guard clears the half-select address bit on every write path.

An engine pulses `init_start` before each new hash. The block then copies the pristine tables into the working halves of both engines at the same time. Each memory offers one read port and one write port per engine. Reads return data one cycle after the address is presented, so the copy is a pipeline: it reads a pristine word, then writes the matching working word on the next cycle. While the copy runs, the engines have no access to the memories. When the last word has been written, the block raises a one-cycle done pulse, and the engines get the memories back. Reset only returns the copy sequencer to idle and leaves the memory contents alone.

Top module: `sbox_bank`

## Requirements
- R1: After reset `init_busy` and `init_done` are 0. A reset that arrives during a copy stops it, and the memory contents are kept: pristine words and working words that were already copied stay as they were.
- R2: Port p serves memory m = p/2 for engine k = p%2. In memory m, pristine word i (0..255) of engine k sits at address 512 + 256k + i. Its value is ((512m + 256k + i) * 0x9E3779B1 mod 2^32) XOR 0x5A5A5A5A. At power-up the working half (addresses 0..511) holds 0.
- R3: `init_start` is accepted only while the block is idle. After a start pulse is sampled, `init_busy` goes high on the next cycle and stays high for exactly 257 cycles: 256 copy steps and one drain cycle. Start pulses that arrive while busy are ignored.
- R4: `init_done` is high for exactly one cycle, namely the first cycle in which `init_busy` is low again after a copy.
- R5: After a copy, working word 256k + i of every memory m equals pristine word i of engine k.
- R6: When idle, a datapath write with `dp_wr_en` stores its data at the requested address with bit 9 forced to 0. A request with bit 9 set therefore lands in the working half.
- R7: No write ever changes a pristine word. Only the copy sequencer drives a read address with bit 9 set, and only while busy. Datapath reads may still reach either half.
- R8: While `init_busy` is high, datapath writes have no effect on the memory contents.
- R9: Read data for an address presented in one cycle appears on `dp_rd_data` in the next cycle and stays there until the following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| init_start | input | 1 | Request a restore of all working halves |
| init_busy | output | 1 | Restore in progress; datapath access blocked |
| init_done | output | 1 | One-cycle pulse when the restore has finished |
| dp_rd_addr | input | 8*10 | Read address per port, port p at bits [10p+9:10p] |
| dp_rd_data | output | 8*32 | Registered read data per port |
| dp_wr_en | input | 8 | Write enable per port |
| dp_wr_addr | input | 8*10 | Write address per port; bit 9 is ignored |
| dp_wr_data | input | 8*32 | Write data per port |

## Verification
Writes are first tried from a fixed list that mixes in-region addresses, addresses with the half-select bit requested high, and addresses at the edges of each engine's region. Reading back both the working word and its pristine twin distinguishes a correct guard from one that lets a write reach the upper half. A long run of random writes from all eight ports, checked against a shadow model, then separates correct address routing from crossed ports or engines. A full sweep after that confirms every pristine word is intact. Restores are started from a corrupted state, disturbed by writes and extra start pulses while busy, and cut short by reset. These runs show whether the restore is exact, whether it lasts the right number of cycles, and whether contents survive a reset.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  localparam int NUM_INST = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_COPY  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_t;

  // Pristine table word for memory mem_id, engine inst, entry idx.
  function automatic logic [31:0] sbox_seed(input int unsigned mem_id,
                                            input int unsigned inst,
                                            input int unsigned idx,
                                            input int unsigned box_depth);
    logic [31:0] key;
    key = 32'(mem_id * 2 * box_depth + inst * box_depth + idx);
    return (key * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
  endfunction

  // Compose a memory address from half select, engine id and entry index.
  function automatic logic [31:0] sbox_addr(input logic hsel,
                                            input logic inst,
                                            input int unsigned idx,
                                            input int unsigned box_depth);
    return 32'((int'(hsel) * 2 + int'(inst)) * box_depth + idx);
  endfunction

endpackage

// File: rtl/sbox_ram.sv
module sbox_ram #(
  parameter int DW        = 32,
  parameter int BOX_DEPTH = 256,
  parameter int MEM_ID    = 0,
  localparam int DEPTH    = 4 * BOX_DEPTH,
  localparam int HALF     = 2 * BOX_DEPTH,
  localparam int AW       = $clog2(DEPTH),
  localparam int NI       = sbox_pkg::NUM_INST
) (
  input  logic                   clk,
  input  logic [NI-1:0][AW-1:0]  rd_addr,
  output logic [NI-1:0][DW-1:0]  rd_data,
  input  logic [NI-1:0]          wr_en,
  input  logic [NI-1:0][AW-1:0]  wr_addr,
  input  logic [NI-1:0][DW-1:0]  wr_data
);

  logic [DW-1:0] mem [DEPTH];

  // Working half starts at zero; pristine half holds the seed tables.
  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      if (a >= HALF)
        mem[a] = DW'(sbox_pkg::sbox_seed(MEM_ID, (a - HALF) / BOX_DEPTH,
                                         a % BOX_DEPTH, BOX_DEPTH));
      else
        mem[a] = '0;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NI; k++) begin
      if (wr_en[k]) mem[wr_addr[k]] <= wr_data[k];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NI; k++) begin
      rd_data[k] <= mem[rd_addr[k]];
    end
  end

endmodule

// File: rtl/sbox_init_seq.sv
module sbox_init_seq #(
  parameter int BOX_DEPTH = 256,
  localparam int IW       = $clog2(BOX_DEPTH),
  localparam logic [IW-1:0] LAST_IDX = IW'(BOX_DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          rd_hsel,
  output logic [IW-1:0] rd_idx,
  output logic          wr_vld,
  output logic [IW-1:0] wr_idx
);

  import sbox_pkg::*;

  seq_state_t    state;
  logic [IW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      cnt     <= '0;
      rd_hsel <= 1'b0;
      wr_vld  <= 1'b0;
      wr_idx  <= '0;
      done    <= 1'b0;
    end else begin
      done   <= 1'b0;
      wr_vld <= (state == SEQ_COPY);
      wr_idx <= cnt;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state   <= SEQ_COPY;
            cnt     <= '0;
            rd_hsel <= 1'b1;
          end
        end
        SEQ_COPY: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) begin
            state   <= SEQ_DRAIN;
            rd_hsel <= 1'b0;
          end
        end
        SEQ_DRAIN: begin
          state <= SEQ_IDLE;
          done  <= 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy   = (state != SEQ_IDLE);
  assign rd_idx = cnt;

endmodule

// File: rtl/sbox_port_mux.sv
module sbox_port_mux #(
  parameter int DW        = 32,
  parameter int BOX_DEPTH = 256,
  parameter int INST_ID   = 0,
  localparam int IW       = $clog2(BOX_DEPTH),
  localparam int AW       = IW + 2
) (
  input  logic          busy,
  input  logic          seq_hsel,
  input  logic [IW-1:0] seq_rd_idx,
  input  logic          seq_wr_vld,
  input  logic [IW-1:0] seq_wr_idx,
  input  logic [AW-1:0] dp_rd_addr,
  input  logic          dp_wr_en,
  input  logic [AW-1:0] dp_wr_addr,
  input  logic [DW-1:0] dp_wr_data,
  input  logic [DW-1:0] ram_rd_q,
  output logic [AW-1:0] ram_rd_addr,
  output logic          ram_wr_en,
  output logic [AW-1:0] ram_wr_addr,
  output logic [DW-1:0] ram_wr_data
);

  localparam logic INST_BIT = 1'(INST_ID);

  logic [AW-2:0] wr_low;

  always_comb begin
    if (busy) begin
      ram_rd_addr = AW'(sbox_pkg::sbox_addr(seq_hsel, INST_BIT, seq_rd_idx, BOX_DEPTH));
      ram_wr_en   = seq_wr_vld;
      wr_low      = {INST_BIT, seq_wr_idx};
      ram_wr_data = ram_rd_q;
    end else begin
      ram_rd_addr = dp_rd_addr;
      ram_wr_en   = dp_wr_en;
      wr_low      = dp_wr_addr[AW-2:0];
      ram_wr_data = dp_wr_data;
    end
  end

  // Half-select guard: the write path never sees bit 9 from any requester.
  assign ram_wr_addr = {1'b0, wr_low};

endmodule

// File: rtl/sbox_bank.sv
module sbox_bank #(
  parameter int NUM_MEM   = 4,
  parameter int DW        = 32,
  parameter int BOX_DEPTH = 256,
  localparam int NI       = sbox_pkg::NUM_INST,
  localparam int NP       = NUM_MEM * NI,
  localparam int IW       = $clog2(BOX_DEPTH),
  localparam int AW       = IW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_start,
  output logic             init_busy,
  output logic             init_done,
  input  logic [NP*AW-1:0] dp_rd_addr,
  output logic [NP*DW-1:0] dp_rd_data,
  input  logic [NP-1:0]    dp_wr_en,
  input  logic [NP*AW-1:0] dp_wr_addr,
  input  logic [NP*DW-1:0] dp_wr_data
);

  logic          seq_hsel;
  logic [IW-1:0] seq_rd_idx;
  logic          seq_wr_vld;
  logic [IW-1:0] seq_wr_idx;

  logic [NP*AW-1:0] ram_rd_addr_all;
  logic [NP*DW-1:0] ram_rd_data_all;
  logic [NP-1:0]    ram_wr_en_all;
  logic [NP*AW-1:0] ram_wr_addr_all;
  logic [NP*DW-1:0] ram_wr_data_all;

  sbox_init_seq #(.BOX_DEPTH(BOX_DEPTH)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (init_start),
    .busy    (init_busy),
    .done    (init_done),
    .rd_hsel (seq_hsel),
    .rd_idx  (seq_rd_idx),
    .wr_vld  (seq_wr_vld),
    .wr_idx  (seq_wr_idx)
  );

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    sbox_ram #(.DW(DW), .BOX_DEPTH(BOX_DEPTH), .MEM_ID(m)) u_ram (
      .clk     (clk),
      .rd_addr (ram_rd_addr_all[m*NI*AW +: NI*AW]),
      .rd_data (ram_rd_data_all[m*NI*DW +: NI*DW]),
      .wr_en   (ram_wr_en_all[m*NI +: NI]),
      .wr_addr (ram_wr_addr_all[m*NI*AW +: NI*AW]),
      .wr_data (ram_wr_data_all[m*NI*DW +: NI*DW])
    );

    for (genvar k = 0; k < NI; k++) begin : g_port
      localparam int P = m * NI + k;
      sbox_port_mux #(.DW(DW), .BOX_DEPTH(BOX_DEPTH), .INST_ID(k)) u_mux (
        .busy        (init_busy),
        .seq_hsel    (seq_hsel),
        .seq_rd_idx  (seq_rd_idx),
        .seq_wr_vld  (seq_wr_vld),
        .seq_wr_idx  (seq_wr_idx),
        .dp_rd_addr  (dp_rd_addr[P*AW +: AW]),
        .dp_wr_en    (dp_wr_en[P]),
        .dp_wr_addr  (dp_wr_addr[P*AW +: AW]),
        .dp_wr_data  (dp_wr_data[P*DW +: DW]),
        .ram_rd_q    (ram_rd_data_all[P*DW +: DW]),
        .ram_rd_addr (ram_rd_addr_all[P*AW +: AW]),
        .ram_wr_en   (ram_wr_en_all[P]),
        .ram_wr_addr (ram_wr_addr_all[P*AW +: AW]),
        .ram_wr_data (ram_wr_data_all[P*DW +: DW])
      );
    end
  end

  assign dp_rd_data = ram_rd_data_all;

endmodule

// File: rtl/sbox_bank_chk.sv
module sbox_bank_chk #(
  parameter int NP          = 8,
  parameter int AW          = 10,
  parameter int COPY_CYCLES = 257
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_start,
  input logic             init_busy,
  input logic             init_done,
  input logic             seq_hsel,
  input logic             seq_wr_vld,
  input logic [NP*AW-1:0] ram_rd_addr_all,
  input logic [NP-1:0]    ram_wr_en_all,
  input logic [NP*AW-1:0] ram_wr_addr_all
);

  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_len <= '0;
    else if (init_busy) busy_len <= busy_len + 1'b1;
    else                busy_len <= '0;
  end

  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R7
    wr_half_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr_en_all[p] |-> !ram_wr_addr_all[p*AW + AW - 1]);
  end

  // R8
  busy_no_dp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_busy && !seq_wr_vld) |-> (ram_wr_en_all == '0));

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_busy) |-> $past(init_start));

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_busy) |-> (busy_len == COPY_CYCLES));

  // R4
  done_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> $fell(init_busy));

  // R4
  exit_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_busy) |-> init_done);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !init_done);

  // R7
  hsel_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_hsel |-> init_busy);

endmodule

bind sbox_bank sbox_bank_chk #(.NP(NP), .AW(AW), .COPY_CYCLES(BOX_DEPTH + 1)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .init_start      (init_start),
  .init_busy       (init_busy),
  .init_done       (init_done),
  .seq_hsel        (seq_hsel),
  .seq_wr_vld      (seq_wr_vld),
  .ram_rd_addr_all (ram_rd_addr_all),
  .ram_wr_en_all   (ram_wr_en_all),
  .ram_wr_addr_all (ram_wr_addr_all)
);

// File: tb/test_sbox_bank.sv
`timescale 1ns/1ps
module test_sbox_bank;

  localparam int NM = 4;
  localparam int DW = 32;
  localparam int BD = 256;
  localparam int NP = NM * 2;
  localparam int AW = 10;
  localparam int NV = 12;

  // {port[2:0], addr[9:0], data[31:0]}
  localparam logic [44:0] VEC [NV] = '{
    {3'd0, 10'h005, 32'h1111_1111},
    {3'd0, 10'h205, 32'h2222_2222},
    {3'd1, 10'h1FF, 32'h3333_3333},
    {3'd1, 10'h3FF, 32'h4444_4444},
    {3'd2, 10'h080, 32'h5555_5555},
    {3'd3, 10'h300, 32'h6666_6666},
    {3'd4, 10'h000, 32'h7777_7777},
    {3'd5, 10'h2AA, 32'h8888_8888},
    {3'd6, 10'h0FF, 32'h9999_9999},
    {3'd7, 10'h3C3, 32'hAAAA_AAAA},
    {3'd7, 10'h100, 32'hBBBB_BBBB},
    {3'd6, 10'h200, 32'hCCCC_CCCC}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             init_start = 1'b0;
  logic             init_busy;
  logic             init_done;
  logic [NP*AW-1:0] dp_rd_addr = '0;
  logic [NP*DW-1:0] dp_rd_data;
  logic [NP-1:0]    dp_wr_en = '0;
  logic [NP*AW-1:0] dp_wr_addr = '0;
  logic [NP*DW-1:0] dp_wr_data = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [31:0] shadow [NM][512];

  always #2.5 clk = ~clk;

  sbox_bank i_sbox_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_start (init_start),
    .init_busy  (init_busy),
    .init_done  (init_done),
    .dp_rd_addr (dp_rd_addr),
    .dp_rd_data (dp_rd_data),
    .dp_wr_en   (dp_wr_en),
    .dp_wr_addr (dp_wr_addr),
    .dp_wr_data (dp_wr_data)
  );

  // Seed value restated with 64-bit arithmetic and an explicit modulo.
  function automatic logic [31:0] seed(int m, int k, int i);
    logic [63:0] prod;
    prod = 64'(m * 512 + k * 256 + i) * 64'd2654435761;
    return prod[31:0] ^ 32'h5A5A5A5A;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(int p, logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    dp_rd_addr[p*AW +: AW] = a;
    @(negedge clk);
    d = dp_rd_data[p*DW +: DW];
  endtask

  task automatic wr(int p, logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    dp_wr_en[p] = 1'b1;
    dp_wr_addr[p*AW +: AW] = a;
    dp_wr_data[p*DW +: DW] = d;
    @(negedge clk);
    dp_wr_en[p] = 1'b0;
    shadow[p/2][a[8:0]] = d;
  endtask

  // Start a restore; optionally disturb it with writes and extra starts.
  task automatic run_init(bit disturb, output int blen, output int done_ok);
    @(negedge clk);
    init_start = 1'b1;
    @(negedge clk);
    init_start = disturb;
    blen = 0;
    while (init_busy && blen < 400) begin
      blen++;
      if (disturb && blen == 3) begin
        dp_wr_en[3] = 1'b1;
        dp_wr_addr[3*AW +: AW] = 10'h110;
        dp_wr_data[3*DW +: DW] = 32'hDEAD_BEEF;
      end
      if (disturb && blen == 10) begin
        dp_wr_en[3] = 1'b0;
        init_start = 1'b0;
      end
      if (disturb && blen == 255) begin
        dp_wr_en[0] = 1'b1;
        dp_wr_addr[0 +: AW] = 10'h0FF;
        dp_wr_data[0 +: DW] = 32'h0BAD_F00D;
      end
      @(negedge clk);
    end
    dp_wr_en = '0;
    done_ok = init_done ? 1 : 0;
    @(negedge clk);
    if (init_done) done_ok = 0;
    for (int m = 0; m < NM; m++)
      for (int j = 0; j < 512; j++) shadow[m][j] = seed(m, j / 256, j % 256);
  endtask

  task automatic sweep_working(string req, string what);
    int bad = 0;
    logic [31:0] d, e, fa, fe;
    fa = 0; fe = 0;
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < BD; i++) begin
        rd(p, 10'((p % 2) * 256 + i), d);
        e = seed(p / 2, p % 2, i);
        if (d !== e && bad == 0) begin fa = d; fe = e; end
        if (d !== e) bad++;
      end
    check(bad == 0, req, what, fa, fe);
  endtask

  task automatic sweep_pristine(string req, string what);
    int bad = 0;
    logic [31:0] d, e, fa, fe;
    fa = 0; fe = 0;
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < BD; i++) begin
        rd(p, 10'(512 + (p % 2) * 256 + i), d);
        e = seed(p / 2, p % 2, i);
        if (d !== e && bad == 0) begin fa = d; fe = e; end
        if (d !== e) bad++;
      end
    check(bad == 0, req, what, fa, fe);
  endtask

  task automatic sweep_shadow(string req, string what);
    int bad = 0;
    logic [31:0] d, fa, fe;
    fa = 0; fe = 0;
    for (int m = 0; m < NM; m++)
      for (int j = 0; j < 512; j++) begin
        rd(m * 2, 10'(j), d);
        if (d !== shadow[m][j] && bad == 0) begin fa = d; fe = shadow[m][j]; end
        if (d !== shadow[m][j]) bad++;
      end
    check(bad == 0, req, what, fa, fe);
  endtask

  initial begin
    int blen, dok;
    logic [31:0] d, e;
    repeat (3) @(negedge clk);
    check(init_busy === 1'b0, "R1", "busy in reset", 32'(init_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(init_busy === 1'b0 && init_done === 1'b0, "R1", "idle after reset",
          {30'd0, init_busy, init_done}, 0);

    // R2 power-up contents
    rd(0, 10'h000, d);
    check(d === 32'h0, "R2", "working word at power-up", d, 0);
    rd(5, 10'h3A7, d);
    e = seed(2, 1, 8'hA7);
    check(d === e, "R2", "pristine word layout", d, e);

    // R9 read latency
    @(negedge clk);
    dp_rd_addr[2*AW +: AW] = 10'h210;
    @(negedge clk);
    e = seed(1, 0, 16);
    check(dp_rd_data[2*DW +: DW] === e, "R9", "data one cycle later", dp_rd_data[2*DW +: DW], e);
    dp_rd_addr[2*AW +: AW] = 10'h211;
    #1;
    check(dp_rd_data[2*DW +: DW] === e, "R9", "data held until edge", dp_rd_data[2*DW +: DW], e);
    @(negedge clk);
    e = seed(1, 0, 17);
    check(dp_rd_data[2*DW +: DW] === e, "R9", "next address", dp_rd_data[2*DW +: DW], e);

    // R3 R4 R5 first restore
    run_init(1'b0, blen, dok);
    check(blen == 257, "R3", "busy length", 32'(blen), 257);
    check(dok == 1, "R4", "single done pulse", 32'(dok), 1);
    sweep_working("R5", "working after restore");
    sweep_pristine("R7", "pristine after restore");

    // R6 R7 vector table
    for (int v = 0; v < NV; v++) begin
      int p;
      logic [9:0] a;
      logic [31:0] wd;
      p  = int'(VEC[v][44:42]);
      a  = VEC[v][41:32];
      wd = VEC[v][31:0];
      wr(p, a, wd);
      rd(p, {1'b0, a[8:0]}, d);
      check(d === wd, "R6", $sformatf("vector %0d working", v), d, wd);
      rd(p, {1'b1, a[8:0]}, d);
      e = seed(p / 2, int'(a[8]), int'(a[7:0]));
      check(d === e, "R7", $sformatf("vector %0d pristine", v), d, e);
    end

    // R6 R7 random corruption
    for (int n = 0; n < 400; n++)
      wr(int'($urandom_range(NP - 1)), 10'($urandom), $urandom);
    sweep_shadow("R6", "random writes land in working half");
    sweep_pristine("R7", "pristine after random writes");

    // R3 R5 R8 disturbed restore
    run_init(1'b1, blen, dok);
    check(blen == 257, "R3", "busy length with extra starts", 32'(blen), 257);
    check(dok == 1, "R4", "done after disturbed restore", 32'(dok), 1);
    rd(3, 10'h110, d);
    e = seed(1, 1, 16);
    check(d === e, "R8", "write during busy ignored", d, e);
    rd(0, 10'h0FF, d);
    e = seed(0, 0, 255);
    check(d === e, "R8", "write in last copy cycle ignored", d, e);
    sweep_working("R5", "restore after corruption");
    @(negedge clk);
    check(init_busy === 1'b0, "R3", "no restart from ignored start", 32'(init_busy), 0);

    // R1 reset during restore
    wr(0, 10'h005, 32'hFEED_0005);
    wr(0, 10'h0F0, 32'hFEED_00F0);
    @(negedge clk);
    init_start = 1'b1;
    @(negedge clk);
    init_start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(init_busy === 1'b0 && init_done === 1'b0, "R1", "idle after mid-copy reset",
          {30'd0, init_busy, init_done}, 0);
    rd(0, 10'h005, d);
    e = seed(0, 0, 5);
    check(d === e, "R1", "copied word kept through reset", d, e);
    rd(0, 10'h0F0, d);
    check(d === 32'hFEED_00F0, "R1", "uncopied word kept through reset", d, 32'hFEED_00F0);
    sweep_pristine("R1", "pristine kept through reset");
    run_init(1'b0, blen, dok);
    check(blen == 257 && dok == 1, "R3", "restore after reset", 32'(blen), 257);
    sweep_working("R5", "restore after reset");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule